// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip sink for a stream of 32-bit trace words. Incoming words are written into a circular RAM at a write pointer that wraps modulo the RAM depth. A separate read pointer lets software drain the RAM through a register window. A status bit records that the write pointer has wrapped. When the bit is set, the oldest valid word sits at the write pointer. When it is clear, valid data runs from address 0 up to the write pointer.

Software drives the block through a simple APB-style register port. A transfer takes effect in the access cycle, when `psel` and `penable` are both high. Capture can be halted in two ways. The first is a post-trigger word count: once a trigger is seen, a programmed number of further words is stored and then capture stops. The second is a manual flush. The flush request bit self-clears after a fixed delay, and the write pointer is first padded with zero words up to the next 4-word frame boundary. After that, a formatter-stopped status reports the halt once capture is disabled.

Top module: `trace_ring_sink`

## Requirements
- R1: After reset both pointers are 0, status (0x00C) reads 0, control (0x020) reads 0, both formatter registers (0x300, 0x304) read 0, and the depth register (0x004) returns the DEPTH parameter with bit 31 clear.
- R2: Each write to the RAM write-data register (0x024) stores the word at the write pointer, and the pointer then steps by one modulo DEPTH. The write pointer (0x018) can be read and loaded directly.
- R3: Each read of the RAM read-data register (0x010) returns the word at the read pointer, and the pointer then steps by one modulo DEPTH. The read pointer (0x014) can be read and loaded directly.
- R4: Status bit 0 is set when the write pointer steps from DEPTH-1 to 0 by any RAM write. Any write to the write-pointer register clears it.
- R5: Control bit 0 is the capture enable. A trace word with `trc_valid` high is stored only while it is 1. While it is 0, the write pointer does not move.
- R6: The trigger-count register (0x01C) holds N. With formatter-control bit 13 set and capture enabled, a `trc_trigger` pulse stores its own word (if valid) and then exactly N more valid words, after which capture halts. Capture stays halted until control is written with bit 0 = 1.
- R7: Writing formatter-control (0x304) with bit 6 = 1 starts a manual flush. Bit 6 of 0x304 and bit 0 of formatter-status (0x300) read 1 for at least FLUSH_CYCLES cycles, then clear by themselves.
- R8: Before a flush completes, zero words are written until the write pointer is a multiple of 4. At completion the write pointer is frame aligned.
- R9: Formatter-status bit 1 reads 1 only after a completed flush while control bit 0 is 0. A new flush request, or a control write with bit 0 = 1, clears it.
- R10: With formatter-control bit 12 set, trace words are ignored after a flush completes, until control is written with bit 0 = 1.
- R11: Formatter-control bits 0, 12 and 13 read back as written, and all other bits read 0 once no flush is running. Unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Register byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for the addressed register |
| trc_valid | input | 1 | Trace word present this cycle |
| trc_data | input | 32 | Trace word |
| trc_trigger | input | 1 | Trigger event marker |

## Verification
The embedded properties check, on every cycle, how the pointers step: the write pointer moves only on a RAM write and stays still when capture is off, the read pointer advances on a data read, and the wrap flag sets on a roll-over and clears on a pointer load. They also check that a flush stays busy for at least its programmed delay, ends on a frame boundary, and never shows stopped while busy. Only the scenarios can show the data path end to end. That covers the words read back after a wrap, the exact number of words kept after a trigger (including a zero count), the zero padding seen in RAM, and a halt followed by a restart.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  // Register byte offsets (software decodes these)
  localparam logic [11:0] OFS_DEPTH = 12'h004;
  localparam logic [11:0] OFS_STAT  = 12'h00C;
  localparam logic [11:0] OFS_RDATA = 12'h010;
  localparam logic [11:0] OFS_RPTR  = 12'h014;
  localparam logic [11:0] OFS_WPTR  = 12'h018;
  localparam logic [11:0] OFS_TRIG  = 12'h01C;
  localparam logic [11:0] OFS_CTRL  = 12'h020;
  localparam logic [11:0] OFS_WDATA = 12'h024;
  localparam logic [11:0] OFS_FSTAT = 12'h300;
  localparam logic [11:0] OFS_FCTRL = 12'h304;

  // Formatter control / status bit positions
  localparam int FC_FMT_EN     = 0;
  localparam int FC_FLUSH      = 6;
  localparam int FC_STOP_FLUSH = 12;
  localparam int FC_STOP_TRIG  = 13;
  localparam int FS_BUSY       = 0;
  localparam int FS_STOPPED    = 1;

  typedef enum logic [1:0] {FL_IDLE, FL_WAIT, FL_PAD} flush_state_e;
endpackage

// File: rtl/tcb_regs.sv
module tcb_regs import tcb_pkg::*; #(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [11:0]       paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [$clog2(DEPTH)-1:0] wr_ptr,
  input  logic [$clog2(DEPTH)-1:0] rd_ptr,
  input  logic [31:0]       rd_word,
  input  logic              wrapped,
  input  logic              flush_busy,
  input  logic              fmt_stopped,
  output logic              cap_en,
  output logic [31:0]       trig_count,
  output logic              stop_on_flush,
  output logic              stop_on_trig,
  output logic              ev_wdata,
  output logic              ev_rdata,
  output logic              ev_ld_rptr,
  output logic              ev_ld_wptr,
  output logic              ev_flush_req,
  output logic              ev_restart
);
  localparam logic [31:0] DEPTH_WORD = 32'(DEPTH) & 32'h7FFF_FFFF;

  logic acc_wr, acc_rd, fmt_en;
  logic [31:0] fstat_word, fctrl_word;

  assign acc_wr = psel && penable && pwrite;
  assign acc_rd = psel && penable && !pwrite;

  // Named access events consumed by the pointer and sequencing logic
  assign ev_wdata     = acc_wr && (paddr == OFS_WDATA);
  assign ev_rdata     = acc_rd && (paddr == OFS_RDATA);
  assign ev_ld_rptr   = acc_wr && (paddr == OFS_RPTR);
  assign ev_ld_wptr   = acc_wr && (paddr == OFS_WPTR);
  assign ev_flush_req = acc_wr && (paddr == OFS_FCTRL) && pwdata[FC_FLUSH];
  assign ev_restart   = acc_wr && (paddr == OFS_CTRL) && pwdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en        <= 1'b0;
      trig_count    <= '0;
      fmt_en        <= 1'b0;
      stop_on_flush <= 1'b0;
      stop_on_trig  <= 1'b0;
    end else if (acc_wr) begin
      case (paddr)
        OFS_TRIG: trig_count <= pwdata;
        OFS_CTRL: cap_en     <= pwdata[0];
        OFS_FCTRL: begin
          fmt_en        <= pwdata[FC_FMT_EN];
          stop_on_flush <= pwdata[FC_STOP_FLUSH];
          stop_on_trig  <= pwdata[FC_STOP_TRIG];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    fstat_word = '0;
    fstat_word[FS_BUSY]    = flush_busy;
    fstat_word[FS_STOPPED] = fmt_stopped;
    fctrl_word = '0;
    fctrl_word[FC_FMT_EN]     = fmt_en;
    fctrl_word[FC_FLUSH]      = flush_busy;
    fctrl_word[FC_STOP_FLUSH] = stop_on_flush;
    fctrl_word[FC_STOP_TRIG]  = stop_on_trig;
  end

  always_comb begin
    case (paddr)
      OFS_DEPTH: prdata = DEPTH_WORD;
      OFS_STAT:  prdata = {31'd0, wrapped};
      OFS_RDATA: prdata = rd_word;
      OFS_RPTR:  prdata = 32'(rd_ptr);
      OFS_WPTR:  prdata = 32'(wr_ptr);
      OFS_TRIG:  prdata = trig_count;
      OFS_CTRL:  prdata = {31'd0, cap_en};
      OFS_FSTAT: prdata = fstat_word;
      OFS_FCTRL: prdata = fctrl_word;
      default:   prdata = '0;
    endcase
  end

  // R11: mode bits follow the last formatter-control write
  a_r11_fctrl_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && paddr == OFS_FCTRL) |=>
      (stop_on_trig == $past(pwdata[FC_STOP_TRIG]) &&
       stop_on_flush == $past(pwdata[FC_STOP_FLUSH])))
    else $error("a_r11_fctrl_keep");
endmodule

// File: rtl/tcb_ptrs.sv
module tcb_ptrs #(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apb_wr,
  input  logic [31:0]       apb_data,
  input  logic              cap_word,
  input  logic [31:0]       trc_data,
  input  logic              pad_word,
  input  logic              rd_step,
  input  logic              ld_rptr,
  input  logic              ld_wptr,
  input  logic [$clog2(DEPTH)-1:0] ld_val,
  output logic [$clog2(DEPTH)-1:0] wr_ptr,
  output logic [$clog2(DEPTH)-1:0] rd_ptr,
  output logic [31:0]       rd_word,
  output logic              wrapped
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return AW'(p + 1'b1);
  endfunction

  logic [31:0] mem [DEPTH];
  logic        wr_fire;
  logic [31:0] wr_val;

  // Write port priority: frame padding, then register writes, then trace
  assign wr_fire = pad_word || apb_wr || cap_word;
  assign wr_val  = pad_word ? 32'd0 : (apb_wr ? apb_data : trc_data);
  assign rd_word = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_fire && !ld_wptr) mem[wr_ptr] <= wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      wrapped <= 1'b0;
    end else begin
      if (ld_wptr) begin
        wr_ptr  <= ld_val;
        wrapped <= 1'b0;
      end else if (wr_fire) begin
        wr_ptr <= ptr_step(wr_ptr);
        if (wr_ptr == LAST) wrapped <= 1'b1;
      end
      if (ld_rptr)      rd_ptr <= ld_val;
      else if (rd_step) rd_ptr <= ptr_step(rd_ptr);
    end
  end

  a_r2_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !ld_wptr) |=> wr_ptr == ptr_step($past(wr_ptr)))
    else $error("a_r2_wr_step");
  a_r3_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && !ld_rptr) |=> rd_ptr == ptr_step($past(rd_ptr)))
    else $error("a_r3_rd_step");
  a_r4_wrap_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !ld_wptr && wr_ptr == LAST) |=> wrapped)
    else $error("a_r4_wrap_set");
  a_r4_wrap_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wptr |=> !wrapped)
    else $error("a_r4_wrap_clear");
endmodule

// File: rtl/tcb_seq.sv
module tcb_seq import tcb_pkg::*; #(
  parameter int FLUSH_CYCLES = 4,
  parameter int FRAME_WORDS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  logic        stop_on_trig,
  input  logic        stop_on_flush,
  input  logic [31:0] trig_count,
  input  logic        trc_valid,
  input  logic        trc_trigger,
  input  logic        ev_wdata,
  input  logic        ev_ld_wptr,
  input  logic        ev_flush_req,
  input  logic        ev_restart,
  input  logic [$clog2(FRAME_WORDS)-1:0] frame_off,
  output logic        cap_word,
  output logic        pad_word,
  output logic        flush_busy,
  output logic        fmt_stopped
);
  localparam int CW = (FLUSH_CYCLES > 1) ? $clog2(FLUSH_CYCLES) : 1;

  flush_state_e state;
  logic [CW-1:0] cnt;
  logic          armed, flush_halt, flush_done, trig_stop;
  logic [31:0]   remain;

  assign trig_stop   = armed && (remain == 32'd0);
  assign flush_busy  = (state != FL_IDLE);
  assign pad_word    = (state == FL_PAD) && (frame_off != '0);
  assign fmt_stopped = flush_done && !cap_en;
  assign cap_word    = cap_en && trc_valid && !trig_stop && !flush_halt &&
                       (state != FL_PAD) && !ev_wdata && !ev_ld_wptr;

  // Post-trigger word countdown
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      remain <= '0;
    end else if (ev_restart) begin
      armed  <= 1'b0;
      remain <= '0;
    end else if (!armed && trc_trigger && cap_en && stop_on_trig && !flush_halt) begin
      armed  <= 1'b1;
      remain <= trig_count;
    end else if (armed && cap_word && remain != 32'd0) begin
      remain <= remain - 32'd1;
    end
  end

  // Manual flush: fixed wait, then pad to a frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= FL_IDLE;
      cnt        <= '0;
      flush_halt <= 1'b0;
      flush_done <= 1'b0;
    end else begin
      case (state)
        FL_IDLE: if (ev_flush_req) begin
          state      <= FL_WAIT;
          cnt        <= CW'(FLUSH_CYCLES - 1);
          flush_done <= 1'b0;
        end
        FL_WAIT: if (cnt == '0) state <= FL_PAD;
                 else cnt <= cnt - 1'b1;
        FL_PAD: if (frame_off == '0) begin
          state      <= FL_IDLE;
          flush_done <= 1'b1;
          flush_halt <= flush_halt || stop_on_flush;
        end
        default: state <= FL_IDLE;
      endcase
      if (ev_restart) begin
        flush_halt <= 1'b0;
        flush_done <= 1'b0;
      end
    end
  end

  // Checker support: length of the current busy stretch
  logic [31:0] busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_len <= '0;
    else        busy_len <= flush_busy ? busy_len + 32'd1 : 32'd0;
  end

  a_r7_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_flush_req && !flush_busy) |=> flush_busy)
    else $error("a_r7_req_busy");
  a_r7_min_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_busy) |-> busy_len >= 32'(FLUSH_CYCLES))
    else $error("a_r7_min_busy");
  a_r8_done_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_busy) |-> frame_off == '0)
    else $error("a_r8_done_aligned");
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_stopped |-> !flush_busy)
    else $error("a_r9_stop_idle");
endmodule

// File: rtl/trace_ring_sink.sv
module trace_ring_sink import tcb_pkg::*; #(
  parameter int DEPTH        = 64,
  parameter int FLUSH_CYCLES = 4,
  parameter int FRAME_WORDS  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  input  logic        trc_valid,
  input  logic [31:0] trc_data,
  input  logic        trc_trigger
);
  localparam int AW = $clog2(DEPTH);
  localparam int FB = $clog2(FRAME_WORDS);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [31:0]   rd_word, trig_count;
  logic wrapped, flush_busy, fmt_stopped, cap_en, stop_on_flush, stop_on_trig;
  logic ev_wdata, ev_rdata, ev_ld_rptr, ev_ld_wptr, ev_flush_req, ev_restart;
  logic cap_word, pad_word;

  tcb_regs #(.DEPTH(DEPTH)) u_regs (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .wr_ptr, .rd_ptr, .rd_word, .wrapped, .flush_busy, .fmt_stopped,
    .cap_en, .trig_count, .stop_on_flush, .stop_on_trig,
    .ev_wdata, .ev_rdata, .ev_ld_rptr, .ev_ld_wptr, .ev_flush_req, .ev_restart
  );

  tcb_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk, .rst_n,
    .apb_wr(ev_wdata), .apb_data(pwdata),
    .cap_word, .trc_data, .pad_word,
    .rd_step(ev_rdata), .ld_rptr(ev_ld_rptr), .ld_wptr(ev_ld_wptr),
    .ld_val(pwdata[AW-1:0]),
    .wr_ptr, .rd_ptr, .rd_word, .wrapped
  );

  tcb_seq #(.FLUSH_CYCLES(FLUSH_CYCLES), .FRAME_WORDS(FRAME_WORDS)) u_seq (
    .clk, .rst_n, .cap_en, .stop_on_trig, .stop_on_flush, .trig_count,
    .trc_valid, .trc_trigger, .ev_wdata, .ev_ld_wptr, .ev_flush_req, .ev_restart,
    .frame_off(wr_ptr[FB-1:0]),
    .cap_word, .pad_word, .flush_busy, .fmt_stopped
  );

  // R5: with capture off and no other writer, the write pointer holds
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !ev_wdata && !pad_word && !ev_ld_wptr) |=> $stable(wr_ptr))
    else $error("a_r5_idle_hold");
endmodule

// File: tb/test_trace_ring_sink.sv
`timescale 1ns/1ps
module test_trace_ring_sink;
  localparam logic [11:0] A_DEPTH = 12'h004, A_STAT = 12'h00C, A_RDATA = 12'h010,
                          A_RPTR = 12'h014, A_WPTR = 12'h018, A_TRIG = 12'h01C,
                          A_CTRL = 12'h020, A_WDATA = 12'h024, A_FSTAT = 12'h300,
                          A_FCTRL = 12'h304;
  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic trc_valid = 0, trc_trigger = 0;
  logic [31:0] trc_data = '0;

  always #2 clk = ~clk;  // 250 MHz

  trace_ring_sink i_trace_ring_sink (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata,
    .trc_valid, .trc_data, .trc_trigger
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] sb_exp[$], sb_mask[$];
  string       sb_tag[$];

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  // Driver: queue the expected item, then perform the read
  task automatic apb_read(input logic [11:0] a, input logic [31:0] exp,
                          input logic [31:0] mask, input string tag);
    sb_exp.push_back(exp); sb_mask.push_back(mask); sb_tag.push_back(tag);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic apb_peek(input logic [11:0] a, output logic [31:0] v);
    sb_exp.push_back('0); sb_mask.push_back('0); sb_tag.push_back("peek");
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 v = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic trace_push(input logic [31:0] d, input logic trig);
    @(negedge clk); trc_valid = 1; trc_data = d; trc_trigger = trig;
    @(negedge clk); trc_valid = 0; trc_trigger = 0;
  endtask

  task automatic wait_flush();
    logic [31:0] v;
    for (int i = 0; i < 40; i++) begin
      apb_peek(A_FCTRL, v);
      if (!v[6]) break;
    end
  endtask

  // Monitor: pop and compare on every read access
  initial forever begin
    @(negedge clk); #1;
    if (psel && penable && !pwrite) begin
      if (sb_exp.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: got read of 0x%08h expected none", prdata);
      end else begin
        logic [31:0] e, m; string t;
        e = sb_exp.pop_front(); m = sb_mask.pop_front(); t = sb_tag.pop_front();
        if (m != '0) begin
          checks++;
          if ((prdata & m) !== (e & m)) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", t, prdata & m, e & m);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    apb_read(A_DEPTH, 32'd64, ALL, "R1 depth");
    apb_read(A_STAT,  0, ALL, "R1 status");
    apb_read(A_WPTR,  0, ALL, "R1 wptr");
    apb_read(A_RPTR,  0, ALL, "R1 rptr");
    apb_read(A_CTRL,  0, ALL, "R1 ctrl");
    apb_read(A_FSTAT, 0, ALL, "R1 fstat");
    apb_read(A_FCTRL, 0, ALL, "R1 fctrl");

    // R11 readback and unmapped space
    apb_write(A_FCTRL, 32'h0000_3001);
    apb_read(A_FCTRL, 32'h0000_3001, ALL, "R11 fctrl bits");
    apb_write(A_FCTRL, 0);
    apb_read(A_FCTRL, 0, ALL, "R11 fctrl clear");
    apb_write(12'h100, 32'hFFFF_FFFF);
    apb_read(12'h100, 0, ALL, "R11 unmapped");
    apb_write(A_TRIG, 32'h1234_5678);
    apb_read(A_TRIG, 32'h1234_5678, ALL, "R6 trig count reg");

    // R2 register writes into RAM
    apb_write(A_WPTR, 5);
    apb_write(A_WDATA, 32'hA5A5_0001);
    apb_write(A_WDATA, 32'hA5A5_0002);
    apb_read(A_WPTR, 7, ALL, "R2 wptr step");
    // R3 reads with auto step
    apb_write(A_RPTR, 5);
    apb_read(A_RDATA, 32'hA5A5_0001, ALL, "R3 read first");
    apb_read(A_RDATA, 32'hA5A5_0002, ALL, "R3 read second");
    apb_read(A_RPTR, 7, ALL, "R3 rptr step");

    // R4 wrap flag
    apb_write(A_WPTR, 63);
    apb_write(A_WDATA, 32'hC0DE_003F);
    apb_read(A_WPTR, 0, ALL, "R2 wptr modulo");
    apb_read(A_STAT, 1, ALL, "R4 wrap set");
    apb_write(A_RPTR, 63);
    apb_read(A_RDATA, 32'hC0DE_003F, ALL, "R3 read last slot");
    apb_read(A_RPTR, 0, ALL, "R3 rptr modulo");
    apb_write(A_WPTR, 0);
    apb_read(A_STAT, 0, ALL, "R4 wrap clear");

    // R5 capture enable
    for (int i = 0; i < 3; i++) trace_push(32'hDEAD_0000 + i, 0);
    apb_read(A_WPTR, 0, ALL, "R5 disabled ignores");
    apb_write(A_CTRL, 1);
    for (int i = 0; i < 3; i++) trace_push(32'hBEEF_0000 + i, 0);
    apb_read(A_WPTR, 3, ALL, "R5 enabled stores");
    apb_write(A_RPTR, 0);
    for (int i = 0; i < 3; i++) apb_read(A_RDATA, 32'hBEEF_0000 + i, ALL, "R5 data");

    // R6 stop on trigger, count 2
    apb_write(A_TRIG, 2);
    apb_write(A_FCTRL, 32'h0000_2000);
    apb_write(A_WPTR, 8);
    apb_write(A_CTRL, 1);
    trace_push(32'h7000_0000, 1);
    for (int i = 1; i < 6; i++) trace_push(32'h7000_0000 + i, 0);
    apb_read(A_WPTR, 11, ALL, "R6 post-trigger count");
    apb_write(A_RPTR, 10);
    apb_read(A_RDATA, 32'h7000_0002, ALL, "R6 last kept word");
    apb_write(A_CTRL, 1);
    trace_push(32'h7100_0000, 0);
    apb_read(A_WPTR, 12, ALL, "R6 restart");
    // R6 count zero
    apb_write(A_TRIG, 0);
    apb_write(A_CTRL, 1);
    trace_push(32'h7200_0000, 1);
    trace_push(32'h7200_0001, 0);
    apb_read(A_WPTR, 13, ALL, "R6 zero count");
    apb_write(A_FCTRL, 0);
    apb_write(A_CTRL, 1);

    // R7 / R8 manual flush from an unaligned pointer
    apb_write(A_FCTRL, 32'h0000_0040);
    apb_read(A_FCTRL, 32'h40, 32'h40, "R7 flush bit busy");
    apb_read(A_FSTAT, 32'h1, 32'h1, "R7 fstat busy");
    wait_flush();
    apb_read(A_FCTRL, 0, 32'h40, "R7 flush self-clear");
    apb_read(A_FSTAT, 0, 32'h3, "R9 not stopped while enabled");
    apb_read(A_WPTR, 16, ALL, "R8 padded to frame");
    apb_write(A_RPTR, 13);
    for (int i = 0; i < 3; i++) apb_read(A_RDATA, 0, ALL, "R8 pad word zero");
    apb_write(A_CTRL, 0);
    apb_read(A_FSTAT, 32'h2, 32'h3, "R9 stopped");
    apb_write(A_CTRL, 1);
    apb_read(A_FSTAT, 0, 32'h3, "R9 cleared by restart");

    // R10 stop on flush
    apb_write(A_FCTRL, 32'h0000_1041);
    wait_flush();
    apb_read(A_FCTRL, 32'h0000_1001, ALL, "R7 R11 fctrl after flush");
    trace_push(32'h7300_00AA, 0);
    trace_push(32'h7300_00BB, 0);
    apb_read(A_WPTR, 16, ALL, "R10 halted after flush");
    apb_write(A_CTRL, 1);
    trace_push(32'h7300_0000, 0);
    apb_read(A_WPTR, 17, ALL, "R10 resumed");
    apb_write(A_RPTR, 16);
    apb_read(A_RDATA, 32'h7300_0000, ALL, "R10 resumed data");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule